// File: doc/BRIEF.md
# SD Card Data FIFO Byte Packer

This block sits between a 32-bit register port and the byte-wide data lane toward an SD card. Data passes through a 16-word circular FIFO. When bytes arrive from the card, they are assembled into words with the first byte in the lowest lane, and software pops those words from the data register. When data goes to the card, software pushes words and the block sends them out one byte at a time, low byte first.

A byte counter limits each transfer. Writing the block-count register loads this counter with the block count times the block size, and the transfer stops when the counter reaches zero. Each card-side word move sets status flags. Block boundaries during a write can raise a block flag. A debug register shows the live FIFO level and a four-bit state field. That field switches to data mode when the last byte has moved.

Both card streams use valid/ready handshakes. A byte moves on a clock edge where valid and ready are both high. The card source may hold `card_rx_valid` high for as long as it needs. `card_tx_valid` stays high with the same byte until the card raises `card_tx_ready`. Register access and the direction inputs are plain strobes and levels.

Top module: `sd_fifo_packer`

## Requirements
- R1: After reset, the status register reads 0, the debug register reads 0x0000C60F, the FIFO is empty, and both card streams are idle. Register byte offsets are: data 0x00, status 0x04, config 0x08, block size 0x0C, block count 0x10, debug 0x14. Reads of any other offset return 0.
- R2: The FIFO holds 16 words and returns them in first-in first-out order. A data-register write while the FIFO is full is dropped. A data-register read while the FIFO is empty returns 0 and does not change the level.
- R3: A write to the block-count register loads the remaining-byte counter with that count times the stored block size. The block-size and block-count registers read back the values written. Exactly that many bytes cross the card interface, one per handshake, and then both card streams go idle.
- R4: In read direction, received bytes fill a word starting at bits 7:0. The word is pushed after its fourth byte.
- R5: If the counter reaches zero partway through a word, that partial word is pushed with its unfilled upper bytes set to zero.
- R6: In write direction, each popped word is sent as four bytes, bits 7:0 first. While `card_tx_ready` is low, `card_tx_valid` and `card_tx_data` hold their values. `card_rx_ready` is low while the FIFO is full.
- R7: Each word pushed by the card side or popped toward the card sets status bit 0. It also sets status bit 8 when config bit 4 is 1.
- R8: In write direction with config bit 8 set, status bit 9 is set each time the bytes sent since the count load reach a multiple of the block size held at that load.
- R9: Writing the status register clears each status bit whose write-data bit is 1.
- R10: Debug bits 8:4 always read the current FIFO level. Stored data cannot overwrite them.
- R11: When the last counted byte moves, debug bits 3:0 become 1. A debug write whose bits 3:0 are 0xF stores 0 in that field. The other written bits are kept.
- R12: With `xfer_read` high, data-register writes are ignored. With `xfer_write` high, data-register reads return 0 and do not pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_read | input | 1 | Card-to-FIFO direction enable |
| xfer_write | input | 1 | FIFO-to-card direction enable |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the data offset) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of reg_rd |
| card_rx_valid | input | 1 | Card byte available |
| card_rx_data | input | 8 | Card byte |
| card_rx_ready | output | 1 | Block accepts a card byte |
| card_tx_valid | output | 1 | Byte offered to the card |
| card_tx_data | output | 8 | Byte toward the card |
| card_tx_ready | input | 1 | Card accepts the byte |

## Verification
The assertions assume that `xfer_read` and `xfer_write` are never high together. They also assume that a register read and a register write are not issued in the same cycle. The stimulus sets at most one direction at a time and issues one register access per task call. It loads the byte counter only when no byte is in flight, and changes direction only when the counter is zero. Card-side valid and ready come from a free-running pseudo-random sequence, so stalls and back-pressure occur at irregular points within words.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  // register byte offsets
  localparam logic [5:0] A_DATA  = 6'h00;
  localparam logic [5:0] A_STAT  = 6'h04;
  localparam logic [5:0] A_CFG   = 6'h08;
  localparam logic [5:0] A_BSIZE = 6'h0C;
  localparam logic [5:0] A_BCNT  = 6'h10;
  localparam logic [5:0] A_DBG   = 6'h14;

  // status and config bit positions
  localparam int ST_DATA     = 0;
  localparam int ST_DATA_IRQ = 8;
  localparam int ST_BLOCK    = 9;
  localparam int CF_DATA_IE  = 4;
  localparam int CF_BLOCK_IE = 8;

  localparam logic [31:0] DBG_RESET = 32'h0000_C60F;
  localparam logic [3:0]  FSM_DATA  = 4'h1;
  localparam logic [3:0]  FSM_PWRDN = 4'hF;

  typedef struct packed {
    logic word;   // a word crossed the FIFO boundary on the card side
    logic blk;    // block boundary reached while sending
    logic last;   // final counted byte moved
  } xfer_evt_t;
endpackage

// File: rtl/sd_word_fifo.sv
module sd_word_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr_q;
  logic [LW-1:0] level_q;
  logic [AW-1:0] wr_idx;
  logic          push_ok, pop_ok;

  assign full    = (level_q == LW'(DEPTH));
  assign empty   = (level_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign wr_idx  = rd_ptr_q + AW'(level_q);
  assign head    = empty ? '0 : mem[rd_ptr_q];
  assign level   = level_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (pop_ok) rd_ptr_q <= rd_ptr_q + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + LW'(1);
        2'b01:   level_q <= level_q - LW'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (level_q == LW'(DEPTH)));
  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (level_q == '0));
endmodule

// File: rtl/sd_byte_engine.sv
module sd_byte_engine
  import sdp_pkg::*;
#(
  parameter int REM_W = 25,
  parameter int BSZ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_mode,
  input  logic             wr_mode,
  input  logic             load,
  input  logic [REM_W-1:0] load_rem,
  input  logic [BSZ_W-1:0] load_bsz,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic [31:0]      fifo_head,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready,
  output logic             push,
  output logic [31:0]      push_data,
  output logic             pop,
  output xfer_evt_t        evt
);
  logic [REM_W-1:0] rem_q;
  logic [BSZ_W-1:0] blk_left_q, blk_size_q;
  logic [1:0]       bidx_q;
  logic [23:0]      hold_q;     // partial word (read) or unsent bytes (write)
  logic             active, rx_fire, tx_fire, last_byte;
  logic [31:0]      packed_word;

  assign active      = (rem_q != '0) && !load;
  assign rx_ready    = rd_mode && active && !fifo_full;
  assign tx_valid    = wr_mode && active && ((bidx_q != 2'd0) || !fifo_empty);
  assign tx_data     = (bidx_q == 2'd0) ? fifo_head[7:0] : hold_q[7:0];
  assign rx_fire     = rx_valid && rx_ready;
  assign tx_fire     = tx_valid && tx_ready;
  assign last_byte   = (rx_fire || tx_fire) && (rem_q == REM_W'(1));
  assign packed_word = {8'h00, hold_q} | ({24'h0, rx_data} << {bidx_q, 3'b000});

  assign push      = rx_fire && ((bidx_q == 2'd3) || last_byte);
  assign push_data = packed_word;
  assign pop       = tx_fire && (bidx_q == 2'd0);
  assign evt.word  = push || pop;
  assign evt.blk   = tx_fire && (blk_left_q == BSZ_W'(1));
  assign evt.last  = last_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q      <= '0;
      blk_left_q <= '0;
      blk_size_q <= '0;
      bidx_q     <= '0;
      hold_q     <= '0;
    end else if (load) begin
      rem_q      <= load_rem;
      blk_left_q <= load_bsz;
      blk_size_q <= load_bsz;
      bidx_q     <= '0;
      hold_q     <= '0;
    end else begin
      if (rx_fire || tx_fire) rem_q <= rem_q - REM_W'(1);
      if (rx_fire) begin
        if (push) begin
          hold_q <= '0;
          bidx_q <= '0;
        end else begin
          hold_q <= packed_word[23:0];
          bidx_q <= bidx_q + 2'd1;
        end
      end else if (tx_fire) begin
        if (last_byte) begin
          hold_q <= '0;
          bidx_q <= '0;
        end else if (bidx_q == 2'd0) begin
          hold_q <= fifo_head[31:8];
          bidx_q <= 2'd3;
        end else begin
          hold_q <= {8'h00, hold_q[23:8]};
          bidx_q <= bidx_q - 2'd1;
        end
      end
      if (tx_fire)
        blk_left_q <= (blk_left_q == BSZ_W'(1)) ? blk_size_q : blk_left_q - BSZ_W'(1);
    end
  end

  // R3
  rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire || tx_fire) |=> (rem_q == $past(rem_q) - REM_W'(1)));
  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (!wr_mode || load || (tx_valid && $stable(tx_data))));
  // R12
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_mode && wr_mode));
endmodule

// File: rtl/sd_fifo_packer.sv
module sd_fifo_packer
  import sdp_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int BSZ_W      = 16,
  parameter int BCNT_W     = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xfer_read,
  input  logic        xfer_write,
  input  logic [5:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        card_rx_valid,
  input  logic [7:0]  card_rx_data,
  output logic        card_rx_ready,
  output logic        card_tx_valid,
  output logic [7:0]  card_tx_data,
  input  logic        card_tx_ready
);
  localparam int REM_W = BSZ_W + BCNT_W;
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic [31:0]       cfg_q;
  logic [BSZ_W-1:0]  bsz_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [31:9]       dbg_hi_q;
  logic [3:0]        dbg_nib_q;
  logic              st_data_q, st_dirq_q, st_blk_q;

  logic wr_data, rd_data, wr_stat, wr_cfg, wr_bsz, wr_bcnt, wr_dbg;
  assign wr_data = reg_wr && (reg_addr == A_DATA);
  assign rd_data = reg_rd && (reg_addr == A_DATA);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_cfg  = reg_wr && (reg_addr == A_CFG);
  assign wr_bsz  = reg_wr && (reg_addr == A_BSIZE);
  assign wr_bcnt = reg_wr && (reg_addr == A_BCNT);
  assign wr_dbg  = reg_wr && (reg_addr == A_DBG);

  logic             f_push, f_pop, f_full, f_empty;
  logic [31:0]      f_wdata, f_head;
  logic [LVL_W-1:0] f_level;
  logic             e_push, e_pop;
  logic [31:0]      e_word;
  xfer_evt_t        evt;
  logic [REM_W-1:0] load_rem;

  assign load_rem = REM_W'(reg_wdata[BCNT_W-1:0]) * REM_W'(bsz_q);
  assign f_push   = e_push || (wr_data && !xfer_read);
  assign f_wdata  = e_push ? e_word : reg_wdata;
  assign f_pop    = e_pop || (rd_data && !xfer_write);

  sd_word_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(f_push), .push_data(f_wdata), .pop(f_pop),
    .head(f_head), .level(f_level), .full(f_full), .empty(f_empty)
  );

  sd_byte_engine #(.REM_W(REM_W), .BSZ_W(BSZ_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .rd_mode(xfer_read), .wr_mode(xfer_write),
    .load(wr_bcnt), .load_rem(load_rem), .load_bsz(bsz_q),
    .fifo_full(f_full), .fifo_empty(f_empty), .fifo_head(f_head),
    .rx_valid(card_rx_valid), .rx_data(card_rx_data), .rx_ready(card_rx_ready),
    .tx_valid(card_tx_valid), .tx_data(card_tx_data), .tx_ready(card_tx_ready),
    .push(e_push), .push_data(e_word), .pop(e_pop), .evt(evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      bsz_q     <= '0;
      bcnt_q    <= '0;
      dbg_hi_q  <= DBG_RESET[31:9];
      dbg_nib_q <= DBG_RESET[3:0];
      st_data_q <= 1'b0;
      st_dirq_q <= 1'b0;
      st_blk_q  <= 1'b0;
    end else begin
      if (wr_cfg)  cfg_q  <= reg_wdata;
      if (wr_bsz)  bsz_q  <= reg_wdata[BSZ_W-1:0];
      if (wr_bcnt) bcnt_q <= reg_wdata[BCNT_W-1:0];
      if (wr_dbg) begin
        dbg_hi_q  <= reg_wdata[31:9];
        dbg_nib_q <= (reg_wdata[3:0] == FSM_PWRDN) ? 4'h0 : reg_wdata[3:0];
      end
      if (evt.last) dbg_nib_q <= FSM_DATA;
      st_data_q <= (st_data_q && !(wr_stat && reg_wdata[ST_DATA])) || evt.word;
      st_dirq_q <= (st_dirq_q && !(wr_stat && reg_wdata[ST_DATA_IRQ]))
                   || (evt.word && cfg_q[CF_DATA_IE]);
      st_blk_q  <= (st_blk_q && !(wr_stat && reg_wdata[ST_BLOCK]))
                   || (evt.blk && cfg_q[CF_BLOCK_IE]);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_DATA:  reg_rdata = xfer_write ? 32'h0 : f_head;
      A_STAT: begin
        reg_rdata[ST_DATA]     = st_data_q;
        reg_rdata[ST_DATA_IRQ] = st_dirq_q;
        reg_rdata[ST_BLOCK]    = st_blk_q;
      end
      A_CFG:   reg_rdata = cfg_q;
      A_BSIZE: reg_rdata = 32'(bsz_q);
      A_BCNT:  reg_rdata = 32'(bcnt_q);
      A_DBG:   reg_rdata = {dbg_hi_q, 5'(f_level), dbg_nib_q};
      default: reg_rdata = '0;
    endcase
  end

  // R7
  data_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.word |=> st_data_q);
  // R8
  block_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.blk && cfg_q[CF_BLOCK_IE]) |=> st_blk_q);
  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[ST_DATA] && !evt.word) |=> !st_data_q);
  // R11
  data_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.last |=> (dbg_nib_q == FSM_DATA));
endmodule

// File: tb/sd_fifo_packer_bench.sv
`timescale 1ns/1ps
module sd_fifo_packer_bench;
  import sdp_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, xfer_read, xfer_write, reg_wr, reg_rd;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        card_rx_valid, card_rx_ready, card_tx_valid, card_tx_ready;
  logic [7:0]  card_rx_data, card_tx_data;

  sd_fifo_packer u_sd_fifo_packer (.*);

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] mq[$];
  logic [7:0]  tx_seen[$];
  logic [31:0] m_cfg, m_dbg, m_stat, m_part, m_txsh;
  int          m_rem, m_size, m_cnt, m_snap, m_nb, m_txn;
  logic [7:0]  rx_byte;
  logic        rx_en, tx_en;
  logic [15:0] lf = 16'hACE1;

  function automatic bit p_rx_ready();
    return xfer_read && m_rem != 0 && mq.size() < 16 && !(reg_wr && reg_addr == A_BCNT);
  endfunction
  function automatic bit p_tx_valid();
    return xfer_write && m_rem != 0 && (m_txn != 0 || mq.size() > 0)
           && !(reg_wr && reg_addr == A_BCNT);
  endfunction
  function automatic logic [7:0] p_tx_data();
    return (m_txn == 0) ? mq[0][7:0] : m_txsh[7:0];
  endfunction
  function automatic logic [31:0] p_rdata();
    case (reg_addr)
      A_DATA:  return (!xfer_write && mq.size() > 0) ? mq[0] : 32'h0;
      A_STAT:  return m_stat;
      A_CFG:   return m_cfg;
      A_BSIZE: return 32'(m_size);
      A_BCNT:  return 32'(m_cnt);
      A_DBG:   return {m_dbg[31:9], 5'(mq.size()), m_dbg[3:0]};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin : ref_model
    bit rxf, txf, done;
    int pre;
    logic [31:0] setb, w, flag;
    if (!rst_n) begin
      mq.delete();
      m_cfg = 0; m_dbg = 32'h0000C60F; m_stat = 0; m_part = 0; m_txsh = 0;
      m_rem = 0; m_size = 0; m_cnt = 0; m_snap = 0; m_nb = 0; m_txn = 0;
    end else begin
      pre  = mq.size();
      rxf  = p_rx_ready() && card_rx_valid;
      txf  = p_tx_valid() && card_tx_ready;
      setb = 0; done = 0;
      flag = m_cfg[4] ? 32'h101 : 32'h001;
      if (reg_rd && reg_addr == A_DATA && !xfer_write && pre > 0) void'(mq.pop_front());
      if (reg_wr && reg_addr == A_DATA && !xfer_read && pre < 16) mq.push_back(reg_wdata);
      if (rxf) begin
        m_part = m_part | ({24'h0, card_rx_data} << (8 * m_nb));
        m_nb++; m_rem--; rx_byte = rx_byte + 8'd1;
        if (m_nb == 4 || m_rem == 0) begin
          mq.push_back(m_part); m_part = 0; m_nb = 0; setb |= flag;
        end
      end
      if (txf) begin
        if (m_txn == 0) begin
          w = mq.pop_front(); tx_seen.push_back(w[7:0]);
          m_txsh = w >> 8; m_txn = 3; setb |= flag;
        end else begin
          tx_seen.push_back(m_txsh[7:0]); m_txsh = m_txsh >> 8; m_txn--;
        end
        m_rem--;
        if (m_rem % m_snap == 0 && m_cfg[8]) setb |= 32'h200;
      end
      if ((rxf || txf) && m_rem == 0) begin
        done = 1; m_part = 0; m_nb = 0; m_txn = 0;
      end
      if (reg_wr && reg_addr == A_STAT) m_stat = m_stat & ~reg_wdata;
      m_stat = (m_stat | setb) & 32'h301;
      if (reg_wr && reg_addr == A_CFG) m_cfg = reg_wdata;
      if (reg_wr && reg_addr == A_BCNT) begin
        m_cnt = int'(reg_wdata[8:0]); m_rem = m_cnt * m_size; m_snap = m_size;
        m_part = 0; m_nb = 0; m_txn = 0;
      end
      if (reg_wr && reg_addr == A_BSIZE) m_size = int'(reg_wdata[15:0]);
      if (reg_wr && reg_addr == A_DBG)
        m_dbg = {reg_wdata[31:4], (reg_wdata[3:0] == 4'hF) ? 4'h0 : reg_wdata[3:0]};
      if (done) m_dbg[3:0] = 4'h1;
    end
  end

  // card-side stimulus: pseudo-random valid/ready
  always @(negedge clk) begin
    lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    card_rx_valid <= rx_en && (lf[0] || lf[3]);
    card_tx_ready <= tx_en && (lf[1] || lf[5]);
    card_rx_data  <= rx_byte;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk(card_rx_ready == p_rx_ready(), "R6 rx_ready", 32'(card_rx_ready), 32'(p_rx_ready()));
      chk(card_tx_valid == p_tx_valid(), "R3 tx_valid", 32'(card_tx_valid), 32'(p_tx_valid()));
      if (card_tx_valid && p_tx_valid())
        chk(card_tx_data == p_tx_data(), "R6 tx_data", 32'(card_tx_data), 32'(p_tx_data()));
      if (reg_rd)
        chk(reg_rdata == p_rdata(), "R2 rdata", reg_rdata, p_rdata());
    end
  end

  // ---------------- register tasks ----------------
  task automatic rwr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic rrd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask
  task automatic rexp(input logic [5:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    rrd(a, v);
    chk(v == e, tag, v, e);
  endtask
  task automatic wait_done();
    for (int i = 0; i < 3000 && m_rem != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 0; xfer_read = 0; xfer_write = 0; reg_wr = 0; reg_rd = 0;
    reg_addr = 0; reg_wdata = 0; rx_en = 0; tx_en = 0; rx_byte = 8'h11;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rexp(A_DBG, 32'h0000C60F, "R1 debug reset");
    rexp(A_STAT, 32'h0, "R1 status reset");
    rexp(6'h3C, 32'h0, "R1 unmapped read");
    chk(!card_rx_ready && !card_tx_valid, "R1 card idle", 32'(card_tx_valid), 32'h0);

    // R2 FIFO order, overflow drop, empty read
    for (int i = 0; i < 17; i++) rwr(A_DATA, 32'h5000_0000 + 32'(i));
    rexp(A_DBG, 32'h0000C70F, "R10 level 16");
    for (int i = 0; i < 16; i++) rexp(A_DATA, 32'h5000_0000 + 32'(i), "R2 fifo order");
    rexp(A_DATA, 32'h0, "R2 empty read");
    rexp(A_DBG, 32'h0000C60F, "R2 level after empty read");

    // card read with partial final word
    rwr(A_CFG, 32'h0000_0110);
    @(negedge clk); xfer_read = 1;
    rwr(A_DATA, 32'hDEAD_BEEF);
    rexp(A_DBG, 32'h0000C60F, "R12 write ignored in read mode");
    rwr(A_BSIZE, 32'd6);
    rwr(A_BCNT, 32'd1);
    rexp(A_BSIZE, 32'd6, "R3 size readback");
    rexp(A_BCNT, 32'd1, "R3 count readback");
    rx_en = 1;
    wait_done();
    rx_en = 0;
    chk(rx_byte == 8'h17, "R3 byte total", 32'(rx_byte), 32'h17);
    chk(!card_rx_ready, "R3 idle after count", 32'(card_rx_ready), 32'h0);
    rexp(A_STAT, 32'h0000_0101, "R7 data flags");
    @(negedge clk); xfer_read = 0;
    rexp(A_DATA, 32'h1413_1211, "R4 packed word");
    rexp(A_DATA, 32'h0000_1615, "R5 partial word");
    rexp(A_DBG, 32'h0000C601, "R11 data mode");
    rwr(A_STAT, 32'h0000_0001);
    rexp(A_STAT, 32'h0000_0100, "R9 w1c");
    rwr(A_STAT, 32'h0000_0301);

    // card write with block flag
    rwr(A_DATA, 32'hA3A2_A1A0);
    rwr(A_DATA, 32'hB3B2_B1B0);
    rwr(A_DATA, 32'hC3C2_C1C0);
    @(negedge clk); xfer_write = 1;
    rexp(A_DATA, 32'h0, "R12 read blocked in write mode");
    rexp(A_DBG, 32'h0000C631, "R12 no pop in write mode");
    tx_seen.delete();
    rwr(A_BSIZE, 32'd4);
    rwr(A_BCNT, 32'd3);
    tx_en = 1;
    wait_done();
    tx_en = 0;
    chk(tx_seen.size() == 12, "R6 byte count", 32'(tx_seen.size()), 32'd12);
    for (int i = 0; i < 12 && i < tx_seen.size(); i++)
      chk(tx_seen[i] == 8'(((i / 4) * 16 + 160) + (i % 4)), "R6 byte order",
          32'(tx_seen[i]), 32'(((i / 4) * 16 + 160) + (i % 4)));
    rexp(A_STAT, 32'h0000_0301, "R8 block flag");
    @(negedge clk); xfer_write = 0;
    rexp(A_DBG, 32'h0000C601, "R10 level after write");
    rwr(A_STAT, 32'h0000_0301);

    // back-pressure on a full FIFO during card read
    @(negedge clk); xfer_read = 1;
    rwr(A_BCNT, 32'd17);
    rx_en = 1;
    for (int i = 0; i < 2000 && mq.size() < 16; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!card_rx_ready, "R6 rx_ready low when full", 32'(card_rx_ready), 32'h0);
    for (int i = 0; i < 16; i++) rrd(A_DATA, v);
    wait_done();
    rx_en = 0;
    rrd(A_DATA, v);
    rexp(A_DBG, 32'h0000C601, "R10 level drained");
    @(negedge clk); xfer_read = 0;

    // debug field writes
    rwr(A_DBG, 32'h0000_ABCF);
    rexp(A_DBG, 32'h0000_AA00, "R11 nibble F stores 0");
    rwr(A_DBG, 32'h0000_1235);
    rexp(A_DBG, 32'h0000_1205, "R10 level field not writable");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule